// File: doc/BRIEF.md
# Lamp Ballast Phase Sequencer

This block is the digital control core of an electronic lamp ballast. It walks the half-bridge through four operating phases: idle, filament pre-heat, ignition and steady run. It also handles shutdown, fault latching and restart. All inputs are single-bit flags from analog comparators, and all outputs are single-bit controls for the analog side. The outputs cover the timing-capacitor charger and discharge switch, the release of the ignition frequency sweep, a request to raise the switching frequency, the half-bridge driver enable and the low-power latch indication.

One external timing capacitor is used for two jobs. In pre-heat and ignition it measures the phase duration: one charge to the high threshold followed by one decay to the low threshold. In run mode it filters faults, so that a fault must last for a full charge and decay cycle before the block shuts down. Each phase enables its own set of protections.

A latched fault is cleared in one of two ways. The lamp can be removed and reinserted, which asserts the relamp flag and then releases it. Or the supply can drop, which asserts the undervoltage flag. Faults reported by the power-factor section are board faults and clear only through undervoltage.

Top module: `ballast_seq_top`

## Requirements
- R1: `uvlo` high resets the block asynchronously to idle. The phase code is 0=idle, 1=pre-heat, 2=ignition, 3=run, 4=off, 5=fault latched, 6=board fault latched. In idle the only active output is `tc_discharge`. Flag inputs pass through two flops. During reset the relamp flop holds 1 and every other flag flop holds 0.
- R2: Pre-heat drives `tc_charge` until the high flag is seen. It then drives neither `tc_charge` nor `tc_discharge` until the low flag is seen, and ignition starts at that point. `freq_release` is low in pre-heat.
- R3: Ignition raises `freq_release` and restarts the timing cycle. The ignition-end flag moves the block to run. If a full charge and decay cycle completes without ignition, the block latches a fault (phase 5).
- R4: In pre-heat both half-bridge current flags are ignored. In ignition the high current flag raises `freq_up` and the low current flag is ignored.
- R5: In run, the low current flag or the end-of-life flag starts the timing charger. The low current flag also raises `freq_up`. If the fault is still present when the decay ends, the block latches a fault. If the fault clears earlier, the filter resets and the capacitor is discharged.
- R6: In run, the high current flag latches a fault on the next state update.
- R7: The relamp flag moves any phase except the board latch to idle. Idle waits for the flag to be released and then starts pre-heat. If the flag is held at turn-on, pre-heat never starts.
- R8: The disable flag moves pre-heat, ignition, run or idle to the off phase (4) without latching. Releasing the flag restarts from pre-heat. The disable flag has no effect in the latched phases.
- R9: The power-factor fault flag moves any phase to the board latch (6). Only `uvlo` clears that latch.
- R10: `drv_en` is high only in pre-heat, ignition and run. `lowpwr_latch` is high only in phases 5 and 6. `tc_discharge` is high whenever the timer is neither charging nor decaying.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| uvlo | input | 1 | Supply undervoltage, asynchronous active-high reset |
| tc_hi_flag | input | 1 | Timing capacitor above high threshold |
| tc_lo_flag | input | 1 | Timing capacitor below low threshold |
| ign_end_flag | input | 1 | Ignition sweep capacitor reached its end level |
| relamp_flag | input | 1 | Lamp absent / relamp sense above threshold |
| disable_flag | input | 1 | External shutdown request |
| hb_lo_flag | input | 1 | Half-bridge current above low threshold |
| hb_hi_flag | input | 1 | Half-bridge current above high threshold |
| eol_flag | input | 1 | End-of-life window comparator outside window |
| pfc_fault_flag | input | 1 | Board fault from power-factor section |
| phase | output | 3 | Current phase code (see R1) |
| tc_charge | output | 1 | Enable timing-capacitor charger |
| tc_discharge | output | 1 | Short the timing capacitor |
| freq_release | output | 1 | Release the frequency sweep capacitor (high impedance) |
| freq_up | output | 1 | Request switching frequency increase |
| drv_en | output | 1 | Half-bridge driver enable |
| lowpwr_latch | output | 1 | Latched low-consumption state |

## Verification
The assertions assume the flags come from quasi-static comparators. Each flag level is therefore taken to hold for several clocks. The two timing flags are taken never to be high together, because the capacitor cannot be above the high threshold and below the low threshold at once. The stimulus holds every flag pattern for six clocks, which is longer than the three-edge latency through the synchronizer and the state register. It also moves the timing flags in the physical order: low, then high with low cleared, then low again.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_PREHEAT = 3'd1,
    PH_IGNITE  = 3'd2,
    PH_RUN     = 3'd3,
    PH_OFF     = 3'd4,
    PH_FAULT   = 3'd5,
    PH_BOARD   = 3'd6
  } phase_e;

  typedef enum logic [1:0] {
    TC_REST   = 2'd0,
    TC_CHARGE = 2'd1,
    TC_DECAY  = 2'd2
  } tc_state_e;

  localparam int NUM_FLAGS  = 9;
  localparam int IDX_TC_HI  = 0;
  localparam int IDX_TC_LO  = 1;
  localparam int IDX_IGN    = 2;
  localparam int IDX_RELAMP = 3;
  localparam int IDX_DIS    = 4;
  localparam int IDX_HB_LO  = 5;
  localparam int IDX_HB_HI  = 6;
  localparam int IDX_EOL    = 7;
  localparam int IDX_PFC    = 8;
endpackage

// File: rtl/ballast_flag_sync.sv
module ballast_flag_sync #(
  parameter int             WIDTH   = 9,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             uvlo,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or posedge uvlo) begin
      if (uvlo) chain <= {STAGES{RST_VAL[i]}};
      else      chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/ballast_tc_timer.sv
module ballast_tc_timer
  import ballast_seq_pkg::*;
(
  input  logic clk,
  input  logic uvlo,
  input  logic en,
  input  logic clr,
  input  logic hi,
  input  logic lo,
  output logic charge,
  output logic decaying,
  output logic done
);
  tc_state_e ts_q, ts_d;

  always_comb begin
    ts_d = ts_q;
    if (clr || !en) ts_d = TC_REST;
    else begin
      case (ts_q)
        TC_REST:   ts_d = TC_CHARGE;
        TC_CHARGE: if (hi) ts_d = TC_DECAY;
        TC_DECAY:  if (lo) ts_d = TC_REST;
        default:   ts_d = TC_REST;
      endcase
    end
  end

  always_ff @(posedge clk or posedge uvlo) begin
    if (uvlo) ts_q <= TC_REST;
    else      ts_q <= ts_d;
  end

  assign charge   = (ts_q == TC_CHARGE);
  assign decaying = (ts_q == TC_DECAY);
  assign done     = decaying && lo;
endmodule

// File: rtl/ballast_seq_top.sv
module ballast_seq_top
  import ballast_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       uvlo,
  input  logic       tc_hi_flag,
  input  logic       tc_lo_flag,
  input  logic       ign_end_flag,
  input  logic       relamp_flag,
  input  logic       disable_flag,
  input  logic       hb_lo_flag,
  input  logic       hb_hi_flag,
  input  logic       eol_flag,
  input  logic       pfc_fault_flag,
  output logic [2:0] phase,
  output logic       tc_charge,
  output logic       tc_discharge,
  output logic       freq_release,
  output logic       freq_up,
  output logic       drv_en,
  output logic       lowpwr_latch
);
  localparam logic [NUM_FLAGS-1:0] SYNC_RST = NUM_FLAGS'(1) << IDX_RELAMP;

  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  assign flags_raw = {pfc_fault_flag, eol_flag, hb_hi_flag, hb_lo_flag,
                      disable_flag, relamp_flag, ign_end_flag, tc_lo_flag, tc_hi_flag};

  ballast_flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .uvlo(uvlo), .d(flags_raw), .q(flags_s)
  );

  logic tc_hi_s, tc_lo_s, ign_s, relamp_s, dis_s, hb_lo_s, hb_hi_s, eol_s, pfc_s;
  assign tc_hi_s  = flags_s[IDX_TC_HI];
  assign tc_lo_s  = flags_s[IDX_TC_LO];
  assign ign_s    = flags_s[IDX_IGN];
  assign relamp_s = flags_s[IDX_RELAMP];
  assign dis_s    = flags_s[IDX_DIS];
  assign hb_lo_s  = flags_s[IDX_HB_LO];
  assign hb_hi_s  = flags_s[IDX_HB_HI];
  assign eol_s    = flags_s[IDX_EOL];
  assign pfc_s    = flags_s[IDX_PFC];

  phase_e st_q, st_d;
  logic   run_fault, tm_en, tm_clr, tm_charge, tm_decay, tm_done;

  // low current and end-of-life both feed the run-mode fault filter
  assign run_fault = hb_lo_s || eol_s;
  assign tm_en     = (st_q == PH_PREHEAT) || (st_q == PH_IGNITE) ||
                     ((st_q == PH_RUN) && run_fault);
  assign tm_clr    = (st_d != st_q);

  ballast_tc_timer u_timer (
    .clk(clk), .uvlo(uvlo), .en(tm_en), .clr(tm_clr),
    .hi(tc_hi_s), .lo(tc_lo_s),
    .charge(tm_charge), .decaying(tm_decay), .done(tm_done)
  );

  // priority: board fault, relamp, disable, phase progress
  always_comb begin
    st_d = st_q;
    if (pfc_s && st_q != PH_BOARD) st_d = PH_BOARD;
    else begin
      case (st_q)
        PH_IDLE: begin
          if (relamp_s)   st_d = PH_IDLE;
          else if (dis_s) st_d = PH_OFF;
          else            st_d = PH_PREHEAT;
        end
        PH_PREHEAT: begin
          if (relamp_s)     st_d = PH_IDLE;
          else if (dis_s)   st_d = PH_OFF;
          else if (tm_done) st_d = PH_IGNITE;
        end
        PH_IGNITE: begin
          if (relamp_s)     st_d = PH_IDLE;
          else if (dis_s)   st_d = PH_OFF;
          else if (ign_s)   st_d = PH_RUN;
          else if (tm_done) st_d = PH_FAULT;
        end
        PH_RUN: begin
          if (relamp_s)                   st_d = PH_IDLE;
          else if (dis_s)                 st_d = PH_OFF;
          else if (hb_hi_s)               st_d = PH_FAULT;
          else if (tm_done && run_fault)  st_d = PH_FAULT;
        end
        PH_OFF: begin
          if (relamp_s)   st_d = PH_IDLE;
          else if (!dis_s) st_d = PH_PREHEAT;
        end
        PH_FAULT: if (relamp_s) st_d = PH_IDLE;
        PH_BOARD: st_d = PH_BOARD;
        default:  st_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge uvlo) begin
    if (uvlo) st_q <= PH_IDLE;
    else      st_q <= st_d;
  end

  assign phase        = st_q;
  assign tc_charge    = tm_charge;
  assign tc_discharge = !(tm_charge || tm_decay);
  assign freq_release = (st_q == PH_IGNITE) || (st_q == PH_RUN);
  assign freq_up      = ((st_q == PH_IGNITE) && hb_hi_s) || ((st_q == PH_RUN) && hb_lo_s);
  assign drv_en       = (st_q == PH_PREHEAT) || (st_q == PH_IGNITE) || (st_q == PH_RUN);
  assign lowpwr_latch = (st_q == PH_FAULT) || (st_q == PH_BOARD);
endmodule

// File: rtl/ballast_seq_chk.sv
module ballast_seq_chk
  import ballast_seq_pkg::*;
(
  input logic       clk,
  input logic       uvlo,
  input logic [2:0] phase,
  input logic       tc_charge,
  input logic       freq_up,
  input logic       drv_en,
  input logic       hb_hi_s
);
  a_r2_ignite_entry: assert property (@(posedge clk) disable iff (uvlo)
    (phase == PH_IGNITE && $past(phase) != PH_IGNITE) |-> $past(phase) == PH_PREHEAT);

  a_r3_run_entry: assert property (@(posedge clk) disable iff (uvlo)
    (phase == PH_RUN && $past(phase) != PH_RUN) |-> $past(phase) == PH_IGNITE);

  a_r4_quiet_preheat: assert property (@(posedge clk) disable iff (uvlo)
    (phase == PH_PREHEAT) |-> !freq_up);

  a_r5_charge_active: assert property (@(posedge clk) disable iff (uvlo)
    tc_charge |-> drv_en);

  a_r6_hi_run_latch: assert property (@(posedge clk) disable iff (uvlo)
    (phase == PH_RUN && hb_hi_s) |=> !drv_en);

  a_r8_off_exit: assert property (@(posedge clk) disable iff (uvlo)
    (phase == PH_OFF) |=> (phase != PH_RUN && phase != PH_IGNITE));

  a_r9_board_sticky: assert property (@(posedge clk) disable iff (uvlo)
    (phase == PH_BOARD) |=> (phase == PH_BOARD));
endmodule

bind ballast_seq_top ballast_seq_chk chk_i (
  .clk(clk), .uvlo(uvlo), .phase(phase), .tc_charge(tc_charge),
  .freq_up(freq_up), .drv_en(drv_en), .hb_hi_s(hb_hi_s)
);

// File: tb/ballast_seq_top_tb_top.sv
module ballast_seq_top_tb_top;
  logic clk = 1'b0;
  logic uvlo = 1'b1;
  // fl bits: [8]pfc [7]eol [6]hb_hi [5]hb_lo [4]dis [3]relamp [2]ign [1]tc_lo [0]tc_hi
  logic [8:0] fl = 9'b000000010;
  logic [2:0] phase;
  logic tc_charge, tc_discharge, freq_release, freq_up, drv_en, lowpwr_latch;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ballast_seq_top dut_i (
    .clk(clk), .uvlo(uvlo),
    .tc_hi_flag(fl[0]), .tc_lo_flag(fl[1]), .ign_end_flag(fl[2]),
    .relamp_flag(fl[3]), .disable_flag(fl[4]), .hb_lo_flag(fl[5]),
    .hb_hi_flag(fl[6]), .eol_flag(fl[7]), .pfc_fault_flag(fl[8]),
    .phase(phase), .tc_charge(tc_charge), .tc_discharge(tc_discharge),
    .freq_release(freq_release), .freq_up(freq_up), .drv_en(drv_en),
    .lowpwr_latch(lowpwr_latch)
  );

  // entry: {flags[8:0], phase[2:0], outs[5:0]}; outs = charge,discharge,release,freq_up,drv_en,lowpwr
  localparam int NV = 24;
  localparam logic [17:0] VEC [NV] = '{
    {9'b000000010, 3'd1, 6'b100010},  // R2 pre-heat charging
    {9'b001100010, 3'd1, 6'b100010},  // R4 current flags ignored in pre-heat
    {9'b000000001, 3'd1, 6'b000010},  // R2 high seen, decaying
    {9'b000000000, 3'd1, 6'b000010},  // R2 still decaying
    {9'b000000010, 3'd2, 6'b101010},  // R3 ignition, timer restarted
    {9'b000100010, 3'd2, 6'b101010},  // R4 low current ignored in ignition
    {9'b001000010, 3'd2, 6'b101110},  // R4 high current -> freq_up
    {9'b000000110, 3'd3, 6'b011010},  // R3 ignition end -> run
    {9'b000100110, 3'd3, 6'b101110},  // R5 low current charges + freq_up
    {9'b000000110, 3'd3, 6'b011010},  // R5 fault gone, filter reset
    {9'b010000110, 3'd3, 6'b101010},  // R5 end-of-life charges
    {9'b010000101, 3'd3, 6'b001010},  // R5 decaying with fault
    {9'b010000110, 3'd5, 6'b010001},  // R5 fault at cycle end latches
    {9'b000001000, 3'd0, 6'b010000},  // R7 relamp asserted -> idle
    {9'b000000010, 3'd1, 6'b100010},  // R7 released -> pre-heat
    {9'b000010010, 3'd4, 6'b010000},  // R8 disable -> off
    {9'b000000010, 3'd1, 6'b100010},  // R8 released -> pre-heat
    {9'b000000001, 3'd1, 6'b000010},  // R2 decaying
    {9'b000000010, 3'd2, 6'b101010},  // R2 ignition
    {9'b000000110, 3'd3, 6'b011010},  // R3 run
    {9'b001000110, 3'd5, 6'b010001},  // R6 high current in run latches
    {9'b100000010, 3'd6, 6'b010001},  // R9 board fault
    {9'b000001010, 3'd6, 6'b010001},  // R9 relamp does not clear board latch
    {9'b000000010, 3'd6, 6'b010001}   // R9 still latched, R10 outputs
  };

  task automatic check(input string req, input logic [2:0] ph, input logic [5:0] o);
    logic [5:0] act;
    act = {tc_charge, tc_discharge, freq_release, freq_up, drv_en, lowpwr_latch};
    n_chk++;
    if (phase !== ph || act !== o) begin
      n_bad++;
      $display("FAIL %s: phase=%0d outs=%b expected phase=%0d outs=%b", req, phase, act, ph, o);
    end
  endtask

  task automatic apply(input logic [8:0] f, input int n);
    fl = f;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1;
    check("R1 reset", 3'd0, 6'b010000);
    repeat (3) @(negedge clk);
    uvlo = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][17:9], 6);
      check($sformatf("R-table step %0d", i), VEC[i][8:6], VEC[i][5:0]);
    end
    // R1: undervoltage clears board latch; relamp held at turn-on (R7)
    fl = 9'b000001010;
    uvlo = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 uvlo clears latch", 3'd0, 6'b010000);
    uvlo = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 relamp at turn-on holds idle", 3'd0, 6'b010000);
    apply(9'b000000010, 6);
    check("R7 release starts pre-heat", 3'd1, 6'b100010);
    // R3: ignition timeout
    apply(9'b000000001, 6);
    apply(9'b000000010, 6);
    check("R3 ignition entered", 3'd2, 6'b101010);
    apply(9'b000000001, 6);
    check("R3 ignition decaying", 3'd2, 6'b001010);
    apply(9'b000000010, 6);
    check("R3 ignition timeout latches", 3'd5, 6'b010001);
    // R8: disable has no effect when latched
    apply(9'b000010010, 6);
    check("R8 disable ignored in latch", 3'd5, 6'b010001);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule